// File: doc/BRIEF.md
# Branch Target Pair Cache

This block is a small set-associative table that sits beside the instruction cache and remembers the first two instructions found at the target of each taken branch. The fetch unit presents a target address for lookup. On a hit, the stored instruction pair is available one clock later, which is one cycle sooner than the instruction cache path could deliver it. When branch resolution confirms a taken branch, the fetch logic writes the target address and its instruction pair into the table.

Software can turn the table off. While it is off, it never reports a hit and it ignores fills. Five independent invalidate inputs clear every entry in a single cycle:

- instruction-cache flash clear
- instruction-cache single-line invalidate
- return from interrupt
- any exception
- a direct software clear

Inside each set, a tree pseudo-LRU chooses the entry to replace. Both hits and fills update it.

Top module: `tgt_pair_cache`

## Requirements
- R1: While reset is high and after it is released, `hit_q` and `pair_q` are zero and the table holds no valid entries, so every lookup misses.
- R2: The set is `addr[5:2]` and the tag is `addr[31:6]`. Bits [1:0] take no part in a match. Four fills with distinct tags into one set can all be found afterwards.
- R3: A hit returns on `pair_q` the exact 64-bit pair that was last written for that address. `pair_q` is zero whenever `hit_q` is low.
- R4: A lookup presented with `lk_req` in one cycle shows its result on `hit_q`/`pair_q` right after the next rising clock edge.
- R5: If an empty set gets four fills of distinct tags with no lookups in between, a fifth distinct tag replaces the first one that was filled.
- R6: If an empty set is filled with tags A, B, C, D and then A hits, a fifth distinct tag replaces B.
- R7: While `tbl_en` is low, lookups report a miss and fills are discarded. A tag filled while the table is off still misses after the table is turned back on.
- R8: A one-cycle pulse on any of the five invalidate inputs clears every entry and all replacement state. All later lookups miss until new fills arrive.
- R9: A lookup in the same cycle as an invalidate pulse reports a miss.
- R10: A fill in the same cycle as an invalidate pulse is discarded.
- R11: A fill whose set and tag are already present overwrites that entry in place. A lookup then returns only the new pair, never a merge of two copies.
- R12: A lookup and a fill in the same cycle see the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_en | input | 1 | Software enable of the table |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Branch target address to look up |
| fill_req | input | 1 | Write request from branch resolution |
| fill_addr | input | 32 | Target address to write |
| fill_pair | input | 64 | Two target instructions, first in the low half |
| inv_icache_flash | input | 1 | Instruction-cache flash clear |
| inv_icache_line | input | 1 | Instruction-cache line invalidate |
| inv_rfi | input | 1 | Return from interrupt |
| inv_exception | input | 1 | Exception taken |
| inv_soft | input | 1 | Direct software clear |
| hit_q | output | 1 | Registered hit flag |
| pair_q | output | 64 | Registered instruction pair, zero on a miss |

## Verification
The embedded properties check these rules on every cycle:
- at most one way matches a lookup;
- a disabled table or an invalidate cycle is followed by a miss;
- an invalidate leaves every valid bit clear;
- a miss carries a zero pair;
- after a fill, the replacement tree for that set no longer points at the way just filled.

Only the bench scenarios can show:
- which entry is evicted after a particular sequence of fills and hits;
- that the stored pair comes back unchanged for each set;
- that fills made while disabled or during an invalidate leave no trace;
- that a same-cycle lookup sees the old contents.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int unsigned INV_SRCS = 5;

  typedef enum int unsigned {
    SRC_FLASH = 0,
    SRC_LINE  = 1,
    SRC_RFI   = 2,
    SRC_EXC   = 3,
    SRC_SOFT  = 4
  } inv_src_e;
endpackage

// File: rtl/tpc_way.sv
module tpc_way #(
  parameter int unsigned SETS   = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned TAG_W  = 26,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [DATA_W-1:0] w_data,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic [TAG_W-1:0]  r_tag,
  input  logic [IDX_W-1:0]  p_idx,
  input  logic [TAG_W-1:0]  p_tag,
  output logic              r_hit,
  output logic [DATA_W-1:0] r_data,
  output logic              p_hit
);
  logic [SETS-1:0]   valid;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS];

  // Valid bits stay in flops so one cycle can clear them all.
  always_ff @(posedge clk) begin
    if (rst || clr)
      valid <= '0;
    else if (we)
      valid[w_idx] <= 1'b1;
  end

  // Tag and data arrays have no reset, so a RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[w_idx]  <= w_tag;
      data_mem[w_idx] <= w_data;
    end
  end

  assign r_hit  = valid[r_idx] && (tag_mem[r_idx] == r_tag);
  assign r_data = data_mem[r_idx];
  assign p_hit  = valid[p_idx] && (tag_mem[p_idx] == p_tag);

  // R8: after a clear, no entry of this way is valid
  p_flash_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (valid == '0));
endmodule

// File: rtl/tpc_plru.sv
module tpc_plru #(
  parameter int unsigned SETS = 16,
  parameter int unsigned WAYS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     t_en,
  input  logic [$clog2(SETS)-1:0]  t_idx,
  input  logic [$clog2(WAYS)-1:0]  t_way,
  input  logic                     f_en,
  input  logic [$clog2(SETS)-1:0]  f_idx,
  input  logic [$clog2(WAYS)-1:0]  f_way,
  output logic [$clog2(WAYS)-1:0]  victim
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned WW    = $clog2(WAYS);
  localparam int unsigned NB    = WAYS - 1;

  logic [NB-1:0] st [SETS];

  // Heap-ordered tree: node n has children 2n+1 and 2n+2.
  // A bit of 0 sends the search to the left child.
  function automatic logic [NB-1:0] touch(input logic [NB-1:0] s,
                                          input logic [WW-1:0] way);
    logic [NB-1:0] r;
    int node;
    r = s;
    node = 0;
    for (int lvl = WW - 1; lvl >= 0; lvl--) begin
      r[node] = ~way[lvl];
      node = 2 * node + 1 + int'(way[lvl]);
    end
    return r;
  endfunction

  function automatic logic [WW-1:0] pick(input logic [NB-1:0] s);
    logic [WW-1:0] v;
    int node;
    node = 0;
    v = '0;
    for (int lvl = WW - 1; lvl >= 0; lvl--) begin
      v[lvl] = s[node];
      node = 2 * node + 1 + int'(s[node]);
    end
    return v;
  endfunction

  logic [NB-1:0] f_base;
  assign f_base = (t_en && (t_idx == f_idx)) ? touch(st[t_idx], t_way) : st[f_idx];
  assign victim = pick(st[f_idx]);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int s = 0; s < SETS; s++) st[s] <= '0;
    end else begin
      if (t_en) st[t_idx] <= touch(st[t_idx], t_way);
      if (f_en) st[f_idx] <= touch(f_base, f_way);
    end
  end

  // Checker state: the last fill seen
  logic             last_f;
  logic [IDX_W-1:0] last_idx;
  logic [WW-1:0]    last_way;
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      last_f   <= 1'b0;
      last_idx <= '0;
      last_way <= '0;
    end else begin
      last_f   <= f_en;
      last_idx <= f_idx;
      last_way <= f_way;
    end
  end

  // R5: the way just filled is not the next victim of its set
  p_victim_moves_r5: assert property (@(posedge clk) disable iff (rst)
    last_f |-> (pick(st[last_idx]) != last_way));
endmodule

// File: rtl/tgt_pair_cache.sv
module tgt_pair_cache #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned SETS   = 16,
  parameter int unsigned WAYS   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tbl_en,
  input  logic                lk_req,
  input  logic [ADDR_W-1:0]   lk_addr,
  input  logic                fill_req,
  input  logic [ADDR_W-1:0]   fill_addr,
  input  logic [2*INSN_W-1:0] fill_pair,
  input  logic                inv_icache_flash,
  input  logic                inv_icache_line,
  input  logic                inv_rfi,
  input  logic                inv_exception,
  input  logic                inv_soft,
  output logic                hit_q,
  output logic [2*INSN_W-1:0] pair_q
);
  import tpc_pkg::*;

  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned WW     = $clog2(WAYS);
  localparam int unsigned OFF_W  = 2;
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int unsigned PAIR_W = 2 * INSN_W;

  logic [INV_SRCS-1:0] src;
  logic wipe, look, put;

  always_comb begin
    src            = '0;
    src[SRC_FLASH] = inv_icache_flash;
    src[SRC_LINE]  = inv_icache_line;
    src[SRC_RFI]   = inv_rfi;
    src[SRC_EXC]   = inv_exception;
    src[SRC_SOFT]  = inv_soft;
  end

  assign wipe = |src;
  assign look = lk_req && tbl_en && !wipe;
  assign put  = fill_req && tbl_en && !wipe;

  logic [IDX_W-1:0] lk_idx, f_idx;
  logic [TAG_W-1:0] lk_tag, f_tag;
  assign lk_idx = lk_addr[OFF_W +: IDX_W];
  assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
  assign f_idx  = fill_addr[OFF_W +: IDX_W];
  assign f_tag  = fill_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]   rh, ph, wsel;
  logic [PAIR_W-1:0] rd [WAYS];
  logic [WW-1:0]     victim, f_way, h_way;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_way
      tpc_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(PAIR_W)) u_way (
        .clk(clk), .rst(rst), .clr(wipe),
        .we(wsel[g]), .w_idx(f_idx), .w_tag(f_tag), .w_data(fill_pair),
        .r_idx(lk_idx), .r_tag(lk_tag),
        .p_idx(f_idx), .p_tag(f_tag),
        .r_hit(rh[g]), .r_data(rd[g]), .p_hit(ph[g])
      );
    end
  endgenerate

  logic              any_hit;
  logic [PAIR_W-1:0] sel_pair;

  always_comb begin
    sel_pair = '0;
    h_way    = '0;
    f_way    = victim;
    for (int w = 0; w < WAYS; w++) begin
      if (rh[w]) begin
        sel_pair = sel_pair | rd[w];
        h_way    = WW'(w);
      end
      if (ph[w]) f_way = WW'(w);
    end
    wsel = '0;
    if (put) wsel[f_way] = 1'b1;
  end

  assign any_hit = look && (|rh);

  tpc_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .rst(rst), .clr(wipe),
    .t_en(any_hit), .t_idx(lk_idx), .t_way(h_way),
    .f_en(put), .f_idx(f_idx), .f_way(f_way),
    .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      pair_q <= '0;
    end else begin
      hit_q  <= any_hit;
      pair_q <= any_hit ? sel_pair : '0;
    end
  end

  // R11: a lookup never matches more than one way
  p_single_match_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rh));
  // R7: a disabled table yields a miss
  p_off_no_hit_r7: assert property (@(posedge clk) disable iff (rst)
    !tbl_en |=> !hit_q);
  // R9: a lookup during an invalidate misses
  p_wipe_miss_r9: assert property (@(posedge clk) disable iff (rst)
    wipe |=> !hit_q);
  // R3: a miss carries a zero pair
  p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !hit_q |-> (pair_q == '0));
endmodule

// File: tb/sim_tgt_pair_cache.sv
module sim_tgt_pair_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_en = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        fill_req = 1'b0;
  logic [31:0] fill_addr = '0;
  logic [63:0] fill_pair = '0;
  logic [4:0]  inv = '0;
  logic        hit_q;
  logic [63:0] pair_q;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tgt_pair_cache u0 (
    .clk(clk), .rst(rst), .tbl_en(tbl_en),
    .lk_req(lk_req), .lk_addr(lk_addr),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_pair(fill_pair),
    .inv_icache_flash(inv[0]), .inv_icache_line(inv[1]), .inv_rfi(inv[2]),
    .inv_exception(inv[3]), .inv_soft(inv[4]),
    .hit_q(hit_q), .pair_q(pair_q)
  );

  function automatic logic [31:0] mk(input int tag, input int idx);
    return {tag[25:0], idx[3:0], 2'b00};
  endfunction

  function automatic logic [63:0] pv(input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic fill(input logic [31:0] a, input logic [63:0] p);
    fill_req = 1'b1; fill_addr = a; fill_pair = p;
    step();
    fill_req = 1'b0;
  endtask

  // Present a lookup, then compare the outputs right after the next edge
  task automatic look(input logic [31:0] a, input bit exp_hit, input logic [63:0] exp_pair, input string req);
    lk_req = 1'b1; lk_addr = a;
    step();
    lk_req = 1'b0;
    chk(hit_q == exp_hit, req, {63'd0, hit_q}, {63'd0, exp_hit});
    chk(pair_q == (exp_hit ? exp_pair : 64'd0), req, pair_q, exp_hit ? exp_pair : 64'd0);
  endtask

  task automatic pulse(input int s);
    inv = '0; inv[s] = 1'b1;
    step();
    inv = '0;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step();
    chk(hit_q == 1'b0 && pair_q == 64'd0, "R1 during reset", pair_q, 64'd0);
    step(); step();
    rst = 1'b0; tbl_en = 1'b1;
    chk(hit_q == 1'b0 && pair_q == 64'd0, "R1 after reset", pair_q, 64'd0);
    look(mk(1, 0), 1'b0, 64'd0, "R1 empty table");

    // R2 R3 R4: sweep every set with four tags
    for (int s = 0; s < 16; s++) begin
      for (int t = 1; t <= 4; t++) fill(mk(t * 7 + s, s), pv(mk(t * 7 + s, s)));
      for (int t = 1; t <= 4; t++)
        look(mk(t * 7 + s, s), 1'b1, pv(mk(t * 7 + s, s)), "R2 R3 R4 sweep");
      look(mk(99, s), 1'b0, 64'd0, "R2 absent tag");
    end
    look(mk(7, 0) | 32'h3, 1'b1, pv(mk(7, 0)), "R2 offset bits ignored");

    // R5: no intervening lookups, fifth fill evicts first
    pulse(4);
    for (int t = 1; t <= 5; t++) fill(mk(t, 2), pv(mk(t, 2)));
    look(mk(1, 2), 1'b0, 64'd0, "R5 first evicted");
    look(mk(2, 2), 1'b1, pv(mk(2, 2)), "R5 second kept");
    look(mk(5, 2), 1'b1, pv(mk(5, 2)), "R5 new present");

    // R6: hit on first tag, fifth fill evicts second
    pulse(4);
    for (int t = 1; t <= 4; t++) fill(mk(t, 3), pv(mk(t, 3)));
    look(mk(1, 3), 1'b1, pv(mk(1, 3)), "R6 touch first");
    fill(mk(5, 3), pv(mk(5, 3)));
    look(mk(2, 3), 1'b0, 64'd0, "R6 second evicted");
    look(mk(1, 3), 1'b1, pv(mk(1, 3)), "R6 first kept");

    // R7: disabled table
    fill(mk(40, 5), pv(mk(40, 5)));
    tbl_en = 1'b0;
    look(mk(40, 5), 1'b0, 64'd0, "R7 disabled lookup");
    fill(mk(41, 5), pv(mk(41, 5)));
    tbl_en = 1'b1;
    look(mk(41, 5), 1'b0, 64'd0, "R7 fill while off dropped");
    look(mk(40, 5), 1'b1, pv(mk(40, 5)), "R7 re-enabled");

    // R8: each invalidate source clears all
    for (int s = 0; s < 5; s++) begin
      fill(mk(50 + s, 6), pv(mk(50 + s, 6)));
      fill(mk(60 + s, 11), pv(mk(60 + s, 11)));
      look(mk(50 + s, 6), 1'b1, pv(mk(50 + s, 6)), "R8 present before");
      pulse(s);
      look(mk(50 + s, 6), 1'b0, 64'd0, "R8 cleared");
      look(mk(60 + s, 11), 1'b0, 64'd0, "R8 cleared other set");
    end

    // R9: lookup coincident with invalidate
    fill(mk(70, 8), pv(mk(70, 8)));
    lk_req = 1'b1; lk_addr = mk(70, 8); inv[3] = 1'b1;
    step();
    lk_req = 1'b0; inv = '0;
    chk(hit_q == 1'b0, "R9 lookup during invalidate", {63'd0, hit_q}, 64'd0);

    // R10: fill coincident with invalidate
    fill_req = 1'b1; fill_addr = mk(71, 9); fill_pair = pv(mk(71, 9)); inv[2] = 1'b1;
    step();
    fill_req = 1'b0; inv = '0;
    look(mk(71, 9), 1'b0, 64'd0, "R10 fill discarded");

    // R11: refill same tag overwrites in place
    fill(mk(80, 12), pv(mk(80, 12)));
    fill(mk(80, 12), ~pv(mk(80, 12)));
    look(mk(80, 12), 1'b1, ~pv(mk(80, 12)), "R11 in-place overwrite");

    // R12: lookup and fill same cycle see old contents
    lk_req = 1'b1; lk_addr = mk(90, 13);
    fill_req = 1'b1; fill_addr = mk(90, 13); fill_pair = pv(mk(90, 13));
    step();
    lk_req = 1'b0; fill_req = 1'b0;
    chk(hit_q == 1'b0, "R12 same-cycle lookup sees old", {63'd0, hit_q}, 64'd0);
    look(mk(90, 13), 1'b1, pv(mk(90, 13)), "R12 visible next");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule